// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the two least significant address bits for a four-beat burst on a synchronous memory. A burst opens with a load strobe. The strobe captures the starting address bits and the ordering to use, and it sets the beat index to zero. From then on, each rising clock edge that samples the active-low advance input low moves the block to the next beat. When the advance input is high, the address holds. After the fourth beat the sequence wraps back to the starting address.

Two orderings are available, picked by the ordering-select input at load time. Interleaved ordering (select high) forms each address as the start address XOR the beat index, which is the pattern some processor families use for cache-line fills. Linear ordering (select low) adds the beat index to the start address modulo four. Read bursts and write bursts use the same sequencing, so the block has no read/write input.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset sets the beat index to 0 and the burst address output to 00.
- R2: When load is high at a rising edge, the start address is captured and the beat index goes to 0, so after that edge the address output equals the loaded start address.
- R3: Load takes priority over advance: load high together with advance low at the same edge gives beat index 0 and the new start address.
- R4: With load low and advance low at a rising edge, the beat index rises by one modulo four (3 is followed by 0).
- R5: With the ordering select high at load (interleaved), the address output equals start XOR beat index. From start 00, 01, 10 and 11 the orders are 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R6: With the ordering select low at load (linear), the address output equals (start + beat index) mod 4, for example 01-10-11-00.
- R7: With load low and advance high at a rising edge, both the address output and the beat index keep their values.
- R8: The ordering select is used only at a load edge. Changing it during a burst does not alter the sequence.
- R9: Four advances after a load bring the address output back to the start address, and the sequence then repeats.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Starts a burst: captures start address and ordering |
| start_addr_i | input | 2 | Starting low-order address bits |
| order_sel_i | input | 1 | 1 = interleaved ordering, 0 = linear ordering |
| adv_n_i | input | 1 | Advance strobe, active low |
| addr_o | output | 2 | Current burst address bits |
| beat_o | output | 2 | Current beat index within the burst |

## Verification
Several rules are checked by properties on every cycle: the step-by-one of the beat index, holding while advance is high, the outcome of a load (including its priority over advance), and the fact that the stored ordering changes only on a load. The actual address orderings can only be shown by the bench scenarios. These are the four interleaved start points, the linear wrap, a change of the ordering select in mid-burst, and long random runs compared against a reference computed in the bench. The bench scenarios also cover wraparound back to the start address and the reset state.

// File: rtl/burst_pkg.sv
package burst_pkg;
    parameter int unsigned BURST_AW = 2;

    typedef logic [BURST_AW-1:0] baddr_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        baddr_t start;
        baddr_t beat;
        order_e order;
    } seq_state_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  baddr_t     start_addr_i,
    input  logic       order_sel_i,
    input  logic       adv_n_i,
    output seq_state_t state_o
);
    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.start = start_addr_i;
            state_d.beat  = '0;
            state_d.order = order_sel_i ? ORD_INTERLEAVE : ORD_LINEAR;
        end else if (!adv_n_i) begin
            state_d.beat = state_q.beat + baddr_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{start: '0, beat: '0, order: ORD_INTERLEAVE};
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

    // ordering may only change on a load edge
    assert_order_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(state_q.order));

    // start address frozen between loads
    assert_start_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(state_q.start));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
(
    input  seq_state_t state_i,
    output baddr_t     addr_o
);
    baddr_t lin_addr, ilv_addr;

    always_comb begin
        lin_addr = state_i.start + state_i.beat;
        ilv_addr = state_i.start ^ state_i.beat;
        addr_o   = (state_i.order == ORD_INTERLEAVE) ? ilv_addr : lin_addr;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned AW = BURST_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          order_sel_i,
    input  logic          adv_n_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] beat_o
);
    localparam int unsigned BEATS = 1 << AW;

    seq_state_t st;
    baddr_t     map_addr;

    burst_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .start_addr_i (baddr_t'(start_addr_i)),
        .order_sel_i  (order_sel_i),
        .adv_n_i      (adv_n_i),
        .state_o      (st)
    );

    burst_addr_map u_map (
        .state_i (st),
        .addr_o  (map_addr)
    );

    assign addr_o = AW'(map_addr);
    assign beat_o = AW'(st.beat);

    initial begin
        assert_width_match_R4: assert (AW == BURST_AW && BEATS == 4);
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (beat_o == '0) && (addr_o == $past(start_addr_i)));

    assert_load_over_adv_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && !adv_n_i) |=> (beat_o == '0));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !adv_n_i) |=> (beat_o == AW'($past(beat_o) + 1'b1)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(beat_o)));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
    localparam realtime TCK = 8ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_i = 1'b0;
    logic [1:0] start_addr_i = 2'b00;
    logic       order_sel_i = 1'b0;
    logic       adv_n_i = 1'b1;
    logic [1:0] addr_o, beat_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [1:0] m_start = 2'b00;
    logic [1:0] m_beat  = 2'b00;
    logic       m_ilv   = 1'b1;

    always #(TCK/2) clk = ~clk;

    burst_addr_gen u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .start_addr_i(start_addr_i),
        .order_sel_i(order_sel_i), .adv_n_i(adv_n_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    function automatic logic [1:0] ref_addr(logic [1:0] s, logic [1:0] b, logic ilv);
        return ilv ? (s ^ b) : 2'(s + b);
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // drive at negedge, model at posedge, then sample at next negedge
    task automatic cyc(logic r, logic ld, logic [1:0] sa, logic sel, logic advn);
        rst = r; load_i = ld; start_addr_i = sa; order_sel_i = sel; adv_n_i = advn;
        @(posedge clk);
        if (r) begin
            m_start = 2'b00; m_beat = 2'b00; m_ilv = 1'b1;
        end else if (ld) begin
            m_start = sa; m_beat = 2'b00; m_ilv = sel;
        end else if (!advn) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
    endtask

    task automatic check_model(string req);
        check(req, addr_o, ref_addr(m_start, m_beat, m_ilv));
        check(req, beat_o, m_beat);
    endtask

    initial begin
        #(TCK * 200000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [1:0] ilv_tab [4][4];
        ilv_tab[0] = '{2'b00, 2'b01, 2'b10, 2'b11};
        ilv_tab[1] = '{2'b01, 2'b00, 2'b11, 2'b10};
        ilv_tab[2] = '{2'b10, 2'b11, 2'b00, 2'b01};
        ilv_tab[3] = '{2'b11, 2'b10, 2'b01, 2'b00};
        void'($urandom(32'd1357));
        @(negedge clk);
        cyc(1, 1, 2'b11, 0, 0);
        cyc(1, 0, 2'b10, 0, 1);
        // R1 reset state
        check("R1", addr_o, 2'b00);
        check("R1", beat_o, 2'b00);

        // R5 interleaved tables
        for (int s = 0; s < 4; s++) begin
            cyc(0, 1, 2'(s), 1, 1);
            check("R2", addr_o, 2'(s));
            for (int b = 1; b < 4; b++) begin
                cyc(0, 0, 2'b00, 1, 0);
                check("R5", addr_o, ilv_tab[s][b]);
            end
            cyc(0, 0, 2'b00, 1, 0);
            check("R9", addr_o, 2'(s));
        end

        // R6 linear 01-10-11-00
        cyc(0, 1, 2'b01, 0, 1);
        check("R6", addr_o, 2'b01);
        cyc(0, 0, 2'b00, 0, 0); check("R6", addr_o, 2'b10);
        cyc(0, 0, 2'b00, 0, 0); check("R6", addr_o, 2'b11);
        cyc(0, 0, 2'b00, 0, 0); check("R6", addr_o, 2'b00);
        check("R4", beat_o, 2'b11);
        cyc(0, 0, 2'b00, 0, 0);
        check("R4", beat_o, 2'b00);
        check("R9", addr_o, 2'b01);

        // R7 hold
        cyc(0, 0, 2'b00, 0, 0);
        for (int k = 0; k < 3; k++) begin
            cyc(0, 0, 2'(k), k[0], 1);
            check("R7", addr_o, 2'b10);
            check("R7", beat_o, 2'b01);
        end

        // R3 load with advance
        cyc(0, 0, 2'b00, 0, 0);
        cyc(0, 1, 2'b10, 1, 0);
        check("R3", beat_o, 2'b00);
        check("R3", addr_o, 2'b10);

        // R8 mode change mid-burst: linear from 11
        cyc(0, 1, 2'b11, 0, 1);
        cyc(0, 0, 2'b00, 1, 0); check("R8", addr_o, 2'b00);
        cyc(0, 0, 2'b00, 1, 0); check("R8", addr_o, 2'b01);
        cyc(0, 0, 2'b00, 1, 0); check("R8", addr_o, 2'b10);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic ld, sel, advn, r;
            logic [1:0] sa;
            r    = ($urandom % 97) == 0;
            ld   = ($urandom % 6) == 0;
            sel  = 1'($urandom);
            advn = ($urandom % 3) == 0;
            sa   = 2'($urandom);
            cyc(r, ld, sa, sel, advn);
            if (r) check_model("R1");
            else if (ld) check_model(advn ? "R2" : "R3");
            else if (advn) check_model("R7");
            else check_model(m_ilv ? "R5" : "R6");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule